// File: doc/BRIEF.md
# Impedance Sweep Mode Sequencer

This block is the control state machine behind a stepped-frequency impedance measurement. A host writes mode commands into a control byte through a simple register write port. The sequencer accepts or rejects each command according to the mode it is in, and it drives the excitation enable, the grounding of the load nodes and the measurement start toward the neighbouring blocks. It also latches the excitation amplitude range and the receive gain bits from the same byte.

A sweep can only begin once the block has been placed in standby. Standby ties both load nodes to ground. An optional initialize mode lets the load settle at the start frequency for as long as the host likes, and no measurement is taken in that mode. Once a sweep starts, the sequencer counts a programmed number of whole excitation cycles, signalled by a tick from the synthesizer, before it fires a one-cycle measurement start. It then waits for the measurement-done input and reports the completed point. After that it either steps to the next frequency and settles again, or, after the final point, holds the excitation on and flags the sweep as finished.

Top module: `sweep_seq`

## Requirements
- R1: After reset, exc_en_o, gnd_o, meas_start_o, step_o, pt_done_o, swp_done_o, err_o, range_o and gain5_o are all 0, and the block is in a powered-down mode that accepts only the standby command.
- R2: A write to address 0x80 carries the command code in bits [7:4], the amplitude range in bits [2:1] and the gain-of-5 select in bit 0. range_o and gain5_o take the new values on every such write, even when the command is rejected. Bit 3 and any write to address 0x81 have no effect.
- R3: The standby command (code 0xB) is accepted in every mode. It aborts any sweep, sets gnd_o=1 and exc_en_o=0 from the next cycle, and clears err_o.
- R4: The initialize command (code 0x1) is accepted only in standby. It sets exc_en_o=1 and gnd_o=0, and while the block stays in this mode no measurement start is ever issued.
- R5: The sweep command (code 0x2) is accepted only in standby or initialize mode. It enables excitation, clears the point index and loads the settling counter.
- R6: An initialize or sweep command given in any other mode is ignored: the mode and the outputs other than range_o and gain5_o are unchanged. It also sets err_o, which stays set until a standby command.
- R7: Command codes other than 0x1, 0x2 and 0xB change no mode and do not set err_o.
- R8: The settling count N is the 16-bit value held at 0x8A (upper byte) and 0x8B (lower byte). At the start of each point, meas_start_o pulses high for exactly one cycle once N tick_i pulses have been counted, or in the first settling cycle when N=0. tick_i outside settling has no effect.
- R9: The point count P is the 16-bit value held at 0x88 (upper byte) and 0x89 (lower byte). A sweep measures P+1 points.
- R10: A meas_done_i pulse after a measurement start produces a one-cycle pt_done_o on the next cycle. For every point except the last, step_o pulses in that same cycle and settling restarts with the full count N.
- R11: On the final point, swp_done_o rises together with pt_done_o and step_o stays low. The block then holds exc_en_o=1 with no further measurement starts, and swp_done_o stays high until a standby command.
- R12: meas_done_i has no effect unless a measurement has been started and has not yet completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Register write data byte |
| tick_i | input | 1 | One pulse per excitation cycle |
| meas_done_i | input | 1 | Measurement of the current point finished |
| exc_en_o | output | 1 | Excitation drive enabled |
| gnd_o | output | 1 | Load nodes tied to ground |
| meas_start_o | output | 1 | One-cycle measurement start |
| range_o | output | 2 | Excitation amplitude range select |
| gain5_o | output | 1 | Receive gain 5 when high, 1 when low |
| step_o | output | 1 | Advance to the next frequency point |
| pt_done_o | output | 1 | Point measurement completed |
| swp_done_o | output | 1 | Final point completed |
| err_o | output | 1 | Out-of-order command seen |

## Verification
The properties assume that wr_i, tick_i and meas_done_i are single-cycle strobes and that the host does not rewrite the settling or point registers while a point is settling. The stimulus therefore drives every strobe for one clock, separated by idle cycles, and programs both registers before each sweep starts. The properties also rely on meas_done_i being raised only by the measurement engine after a start. The bench keeps this rule in the sweep tests, and it raises meas_done_i outside a measurement only on purpose, to show that the pulse is ignored.

// File: rtl/sweep_seq_pkg.sv
package sweep_seq_pkg;

  localparam int CMD_W = 4;

  localparam logic [CMD_W-1:0] CMD_INIT  = 4'h1;
  localparam logic [CMD_W-1:0] CMD_SWEEP = 4'h2;
  localparam logic [CMD_W-1:0] CMD_STBY  = 4'hB;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_STBY,
    ST_INIT,
    ST_SETTLE,
    ST_MEAS,
    ST_HOLD
  } seq_state_e;

endpackage

// File: rtl/sweep_regs.sv
module sweep_regs
  import sweep_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 'h80,
  parameter logic [ADDR_W-1:0] NPTS_ADDR   = 'h88,
  parameter logic [ADDR_W-1:0] SETTLE_ADDR = 'h8A,
  localparam int PAIR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              cmd_vld_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [1:0]        range_o,
  output logic              gain5_o,
  output logic [PAIR_W-1:0] settle_o,
  output logic [PAIR_W-1:0] npts_o
);

  localparam logic [ADDR_W-1:0] NPTS_LO   = ADDR_W'(NPTS_ADDR + 1);
  localparam logic [ADDR_W-1:0] SETTLE_LO = ADDR_W'(SETTLE_ADDR + 1);

  logic [1:0]        range_q;
  logic              gain_q;
  logic [PAIR_W-1:0] settle_q;
  logic [PAIR_W-1:0] npts_q;

  assign cmd_vld_o = wr_i && (addr_i == CTRL_ADDR);
  assign cmd_o     = wdata_i[DATA_W-1 -: CMD_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      range_q  <= '0;
      gain_q   <= 1'b0;
      settle_q <= '0;
      npts_q   <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        CTRL_ADDR: begin
          range_q <= wdata_i[2:1];
          gain_q  <= wdata_i[0];
        end
        SETTLE_ADDR: settle_q[PAIR_W-1:DATA_W] <= wdata_i;
        SETTLE_LO:   settle_q[DATA_W-1:0]      <= wdata_i;
        NPTS_ADDR:   npts_q[PAIR_W-1:DATA_W]   <= wdata_i;
        NPTS_LO:     npts_q[DATA_W-1:0]        <= wdata_i;
        default: ;
      endcase
    end
  end

  assign range_o  = range_q;
  assign gain5_o  = gain_q;
  assign settle_o = settle_q;
  assign npts_o   = npts_q;

endmodule

// File: rtl/sweep_settle_cnt.sv
module sweep_settle_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         en_i,
  input  logic         tick_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (load_i)                      cnt_q <= val_i;
    else if (en_i && tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sweep_pt_cnt.sv
module sweep_pt_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] lim_i,
  output logic         last_o
);

  logic [W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     idx_q <= '0;
    else if (clr_i)  idx_q <= '0;
    else if (inc_i)  idx_q <= idx_q + 1'b1;
  end

  assign last_o = (idx_q == lim_i);

endmodule

// File: rtl/sweep_fsm.sv
module sweep_fsm
  import sweep_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_vld_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             zero_i,
  input  logic             last_i,
  input  logic             done_i,
  output seq_state_e       state_o,
  output logic             load_o,
  output logic             pt_clr_o,
  output logic             pt_inc_o,
  output logic             meas_start_o,
  output logic             pt_done_o,
  output logic             step_o,
  output logic             swp_done_o,
  output logic             err_o
);

  seq_state_e state_q, state_d;
  logic accept, err_set, err_clr, done_pt, step_d, fin;
  logic pt_done_q, step_q, swp_q, err_q;

  always_comb begin
    state_d      = state_q;
    load_o       = 1'b0;
    pt_clr_o     = 1'b0;
    pt_inc_o     = 1'b0;
    meas_start_o = 1'b0;
    accept       = 1'b0;
    err_set      = 1'b0;
    err_clr      = 1'b0;
    done_pt      = 1'b0;
    step_d       = 1'b0;
    fin          = 1'b0;
    if (cmd_vld_i) begin
      unique case (cmd_i)
        CMD_STBY: begin
          state_d = ST_STBY;
          accept  = 1'b1;
          err_clr = 1'b1;
        end
        CMD_INIT: begin
          if (state_q == ST_STBY) begin
            state_d = ST_INIT;
            accept  = 1'b1;
          end else begin
            err_set = 1'b1;
          end
        end
        CMD_SWEEP: begin
          if (state_q == ST_STBY || state_q == ST_INIT) begin
            state_d  = ST_SETTLE;
            accept   = 1'b1;
            load_o   = 1'b1;
            pt_clr_o = 1'b1;
          end else begin
            err_set = 1'b1;
          end
        end
        default: ;
      endcase
    end
    // sequencing runs only when no command took over this cycle
    if (!accept) begin
      unique case (state_q)
        ST_SETTLE: if (zero_i) begin
          meas_start_o = 1'b1;
          state_d      = ST_MEAS;
        end
        ST_MEAS: if (done_i) begin
          done_pt = 1'b1;
          if (last_i) begin
            fin     = 1'b1;
            state_d = ST_HOLD;
          end else begin
            step_d   = 1'b1;
            pt_inc_o = 1'b1;
            load_o   = 1'b1;
            state_d  = ST_SETTLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_OFF;
      pt_done_q <= 1'b0;
      step_q    <= 1'b0;
      swp_q     <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      pt_done_q <= done_pt;
      step_q    <= step_d;
      if (accept)   swp_q <= 1'b0;
      else if (fin) swp_q <= 1'b1;
      if (err_clr)      err_q <= 1'b0;
      else if (err_set) err_q <= 1'b1;
    end
  end

  assign state_o    = state_q;
  assign pt_done_o  = pt_done_q;
  assign step_o     = step_q;
  assign swp_done_o = swp_q;
  assign err_o      = err_q;

endmodule

// File: rtl/sweep_seq.sv
module sweep_seq
  import sweep_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR   = 'h80,
  parameter logic [ADDR_W-1:0] NPTS_ADDR   = 'h88,
  parameter logic [ADDR_W-1:0] SETTLE_ADDR = 'h8A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tick_i,
  input  logic              meas_done_i,
  output logic              exc_en_o,
  output logic              gnd_o,
  output logic              meas_start_o,
  output logic [1:0]        range_o,
  output logic              gain5_o,
  output logic              step_o,
  output logic              pt_done_o,
  output logic              swp_done_o,
  output logic              err_o
);

  localparam int PAIR_W = 2 * DATA_W;

  logic              cmd_vld;
  logic [CMD_W-1:0]  cmd;
  logic [PAIR_W-1:0] settle_val;
  logic [PAIR_W-1:0] npts_val;
  logic              load, pt_clr, pt_inc, zero, last;
  seq_state_e        state;

  sweep_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
    .NPTS_ADDR(NPTS_ADDR), .SETTLE_ADDR(SETTLE_ADDR)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .cmd_vld_o(cmd_vld), .cmd_o(cmd),
    .range_o(range_o), .gain5_o(gain5_o),
    .settle_o(settle_val), .npts_o(npts_val)
  );

  sweep_settle_cnt #(.W(PAIR_W)) u_settle (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .val_i(settle_val),
    .en_i(state == ST_SETTLE), .tick_i(tick_i), .zero_o(zero)
  );

  sweep_pt_cnt #(.W(PAIR_W)) u_pts (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(pt_clr), .inc_i(pt_inc),
    .lim_i(npts_val), .last_o(last)
  );

  sweep_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmd_vld_i(cmd_vld), .cmd_i(cmd),
    .zero_i(zero), .last_i(last), .done_i(meas_done_i),
    .state_o(state), .load_o(load), .pt_clr_o(pt_clr), .pt_inc_o(pt_inc),
    .meas_start_o(meas_start_o), .pt_done_o(pt_done_o), .step_o(step_o),
    .swp_done_o(swp_done_o), .err_o(err_o)
  );

  assign gnd_o    = (state == ST_STBY);
  assign exc_en_o = (state == ST_INIT) || (state == ST_SETTLE) ||
                    (state == ST_MEAS) || (state == ST_HOLD);

endmodule

// File: rtl/sweep_seq_chk.sv
module sweep_seq_chk
  import sweep_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h80
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              meas_done_i,
  input logic              exc_en_o,
  input logic              gnd_o,
  input logic              meas_start_o,
  input logic              step_o,
  input logic              pt_done_o,
  input logic              swp_done_o,
  input logic              err_o
);

  logic stby_wr;
  assign stby_wr = wr_i && (addr_i == CTRL_ADDR) &&
                   (wdata_i[DATA_W-1 -: CMD_W] == CMD_STBY);

  assert_gnd_no_drive_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnd_o |-> !exc_en_o && !meas_start_o);

  assert_stby_takes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_wr |=> gnd_o && !err_o && !swp_done_o);

  assert_err_from_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(wr_i && addr_i == CTRL_ADDR));

  assert_start_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_start_o |=> !meas_start_o);

  assert_start_excited_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_start_o |-> exc_en_o);

  assert_done_follows_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pt_done_o |-> $past(meas_done_i) && exc_en_o);

  assert_step_with_point_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |-> pt_done_o && !swp_done_o);

  assert_final_point_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(swp_done_o) |-> pt_done_o && !step_o && exc_en_o);

endmodule

bind sweep_seq sweep_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .meas_done_i(meas_done_i), .exc_en_o(exc_en_o),
  .gnd_o(gnd_o), .meas_start_o(meas_start_o), .step_o(step_o),
  .pt_done_o(pt_done_o), .swp_done_o(swp_done_o), .err_o(err_o)
);

// File: tb/sweep_seq_test.sv
module sweep_seq_test;

  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       tick_i = 1'b0;
  logic       meas_done_i = 1'b0;
  logic       exc_en_o, gnd_o, meas_start_o, gain5_o;
  logic       step_o, pt_done_o, swp_done_o, err_o;
  logic [1:0] range_o;

  int total = 0;
  int bad = 0;
  bit ended = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  sweep_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .tick_i(tick_i), .meas_done_i(meas_done_i),
    .exc_en_o(exc_en_o), .gnd_o(gnd_o), .meas_start_o(meas_start_o),
    .range_o(range_o), .gain5_o(gain5_o), .step_o(step_o),
    .pt_done_o(pt_done_o), .swp_done_o(swp_done_o), .err_o(err_o)
  );

  // {data[17:10], gnd[9], exc[8], err[7], range[6:5], gain[4], req[3:0]}
  localparam logic [17:0] VEC [14] = '{
    {8'h25, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 4'd6},  // R6 sweep from off
    {8'h10, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 4'd6},  // R6 init from off
    {8'h70, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 4'd7},  // R7 unknown code
    {8'hB3, 1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 4'd3},  // R3 standby
    {8'h70, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 4'd7},  // R7 no error set
    {8'h16, 1'b0, 1'b1, 1'b0, 2'd3, 1'b0, 4'd4},  // R4 init
    {8'h10, 1'b0, 1'b1, 1'b1, 2'd0, 1'b0, 4'd6},  // R6 init twice
    {8'hB0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 4'd3},  // R3
    {8'h20, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 4'd5},  // R5 sweep from standby
    {8'h14, 1'b0, 1'b1, 1'b1, 2'd2, 1'b0, 4'd6},  // R6 init mid sweep
    {8'h2D, 1'b0, 1'b1, 1'b1, 2'd2, 1'b1, 4'd6},  // R6 sweep mid sweep, R2 bit 3
    {8'hB0, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 4'd3},  // R3 abort
    {8'h10, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 4'd4},  // R4
    {8'h20, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 4'd5}   // R5 sweep from init
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic tk();
    @(negedge clk_i); tick_i = 1'b1;
    @(negedge clk_i); tick_i = 1'b0;
  endtask

  task automatic dn();
    @(negedge clk_i); meas_done_i = 1'b1;
    @(negedge clk_i); meas_done_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    idle(2);
    rst_ni = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 gnd", 8'(gnd_o), 8'd0);
    chk("R1 exc", 8'(exc_en_o), 8'd0);
    chk("R1 pulses", {4'd0, meas_start_o, step_o, pt_done_o, swp_done_o}, 8'd0);
    chk("R1 err", 8'(err_o), 8'd0);
    chk("R1 range/gain", {5'd0, range_o, gain5_o}, 8'd0);

    wr(8'h8A, 8'h00);
    wr(8'h8B, 8'h64);
    for (int i = 0; i < 14; i++) begin
      wr(8'h80, VEC[i][17:10]);
      chk($sformatf("R%0d row%0d gnd", VEC[i][3:0], i), 8'(gnd_o), 8'(VEC[i][9]));
      chk($sformatf("R%0d row%0d exc", VEC[i][3:0], i), 8'(exc_en_o), 8'(VEC[i][8]));
      chk($sformatf("R%0d row%0d err", VEC[i][3:0], i), 8'(err_o), 8'(VEC[i][7]));
      chk($sformatf("R2 row%0d range", i), 8'(range_o), 8'(VEC[i][6:5]));
      chk($sformatf("R2 row%0d gain", i), 8'(gain5_o), 8'(VEC[i][4]));
      chk($sformatf("R4 row%0d no start", i), 8'(meas_start_o), 8'd0);
    end

    // R2: address 0x81 has no effect
    wr(8'h80, 8'hB7);
    chk("R2 range", 8'(range_o), 8'd3);
    chk("R2 gain", 8'(gain5_o), 8'd1);
    wr(8'h81, 8'h00);
    chk("R2 0x81 range", 8'(range_o), 8'd3);
    chk("R2 0x81 gain", 8'(gain5_o), 8'd1);
    chk("R2 0x81 mode", {6'd0, gnd_o, exc_en_o}, 8'd2);

    // R8/R9/R10/R11: N=3, P=1
    wr(8'h8B, 8'h03);
    wr(8'h88, 8'h00);
    wr(8'h89, 8'h01);
    wr(8'h80, 8'hB0);
    tk();  // R8 tick in standby ignored
    wr(8'h80, 8'h20);
    dn();
    chk("R12 done while settling", 8'(pt_done_o), 8'd0);
    tk(); tk();
    chk("R8 two ticks", 8'(meas_start_o), 8'd0);
    tk();
    chk("R8 third tick", 8'(meas_start_o), 8'd1);
    idle(1);
    chk("R8 one cycle", 8'(meas_start_o), 8'd0);
    tk(); tk();  // ignored while measuring
    dn();
    chk("R10 pt_done", 8'(pt_done_o), 8'd1);
    chk("R10 step", 8'(step_o), 8'd1);
    chk("R10 swp_done", 8'(swp_done_o), 8'd0);
    idle(1);
    chk("R10 pulse width", {6'd0, pt_done_o, step_o}, 8'd0);
    tk(); tk();
    chk("R10 reload", 8'(meas_start_o), 8'd0);
    tk();
    chk("R8 second point", 8'(meas_start_o), 8'd1);
    idle(1);
    dn();
    chk("R9 last pt_done", 8'(pt_done_o), 8'd1);
    chk("R11 no step", 8'(step_o), 8'd0);
    chk("R11 swp_done", 8'(swp_done_o), 8'd1);
    chk("R11 exc held", 8'(exc_en_o), 8'd1);
    tk(); tk(); tk();
    chk("R11 no start in hold", 8'(meas_start_o), 8'd0);
    dn();
    chk("R12 done in hold", 8'(pt_done_o), 8'd0);
    chk("R11 swp held", 8'(swp_done_o), 8'd1);
    wr(8'h80, 8'h10);
    chk("R6 init in hold", 8'(err_o), 8'd1);
    chk("R11 swp after reject", 8'(swp_done_o), 8'd1);
    wr(8'h80, 8'hB0);
    chk("R11 swp cleared", 8'(swp_done_o), 8'd0);
    chk("R3 err cleared", 8'(err_o), 8'd0);

    // R8 N=0, R9 P=0
    wr(8'h8B, 8'h00);
    wr(8'h89, 8'h00);
    wr(8'h80, 8'h20);
    chk("R8 zero settle", 8'(meas_start_o), 8'd1);
    idle(1);
    dn();
    chk("R9 single point", {6'd0, pt_done_o, swp_done_o}, 8'd3);
    chk("R9 single no step", 8'(step_o), 8'd0);

    // R3 abort during settling
    wr(8'h80, 8'hB0);
    wr(8'h8B, 8'h05);
    wr(8'h80, 8'h20);
    tk(); tk();
    wr(8'h80, 8'hB0);
    chk("R3 abort mode", {6'd0, gnd_o, exc_en_o}, 8'd2);
    tk(); tk(); tk(); tk();
    chk("R3 no start after abort", 8'(meas_start_o), 8'd0);

    finish_run();
  end

endmodule